// File: doc/BRIEF.md
# Three-Counter Event Monitor

This block counts activity inside a processor core. It holds three 32-bit counters. One counts clock cycles only. The other two count whichever core event their 8-bit code selects. Software reaches the unit through a small register port: a 2-bit select, a write strobe, write data and combinational read data. Every field of the control word sits in one register: the run bit, one-shot clears, the divider, the interrupt enables, the sticky overflow flags and both event codes.

The counters have no enable of their own. They all run whenever the global run bit is set. To park a configurable counter, software selects the code of an external trace signal that is held low. An overflow raises that counter's sticky flag. Any flag whose interrupt enable is set drives the single interrupt line. Software clears flags by writing ones to them. Every other field tolerates being rewritten with its current value, so the usual interrupt handler reads the control word and writes it straight back.

Top module: `evmon_top`

## Requirements
- R1: After reset, all four registers read as zero and `irq` is low.
- R2: The register select picks the register: 0 is the control word, 1 is the cycle counter, 2 is event counter 0 and 3 is event counter 1. A write to selects 1 to 3 loads any 32-bit value into that counter, including zero, and a read returns it.
- R3: While control bit 0 (run) is 0, no counter changes except by a register write or a clear bit. While it is 1 and bit 3 is 0, the cycle counter increments on every clock edge. Run takes effect from the edge after the write that sets it, and it still counts on the edge of the write that clears it.
- R4: Event counter 0 takes its code from control bits 27:20 and event counter 1 from bits 19:12. Codes 0x00 to 0x12 select `evt_lines[code]`, which is sampled on each clock edge while run is set.
- R5: Code 0x20 follows `trace_ext`, so the counter stops while that input is low. Codes 0x08 and 0x0E never count, and neither does any code above 0x12 other than 0x20 (0xFF included).
- R6: A counter that increments from 0xFFFFFFFF wraps to 0 and sets its sticky overflow flag, whether or not its interrupt is enabled. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R7: Writing 1 to a flag bit clears that flag, and writing 0 leaves it as it is. Writing back the control word just read clears the flags that were set and changes no other field and no counter.
- R8: `irq` is high exactly when some flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R9: Control bit 1 clears both event counters and bit 2 clears the cycle counter, on the edge of the write. Both bits always read back as 0.
- R10: With control bit 3 set, the cycle counter advances once every 64 run cycles. A 6-bit prescaler sets this rate, and control bit 2 also clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_lines | input | 19 | Core event pulses, line n belongs to code n |
| trace_ext | input | 1 | External trace signal selected by code 0x20 |
| irq | output | 1 | Combined overflow interrupt |

## Verification
The event counters are driven with mixed pulse patterns in which the two selected lines overlap only in part and unselected lines are also active. A counter that took the wrong field or the wrong line would end on a different total. With every line held high, the dead codes, the highest valid code and the trace code show whether the code decoder tells live codes from dead ones. Wrap tests start the counters one or two steps below all ones, both with and without the interrupt enabled, which separates flag setting from interrupt gating. Divider runs of 128, 30, 63 and 1 cycles show whether the prescaler counts exactly 64 cycles and whether the cycle clear bit resets it.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
   // register select values
   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_CYC  = 2'd1;
   localparam logic [1:0] SEL_EV0  = 2'd2;
   localparam logic [1:0] SEL_EV1  = 2'd3;

   // control word layout
   localparam int DATA_W     = 32;
   localparam int B_RUN      = 0;
   localparam int B_CLR_EV   = 1;
   localparam int B_CLR_CYC  = 2;
   localparam int B_DIV      = 3;
   localparam int B_IEN_LO   = 4;   // ev0, ev1, cyc
   localparam int B_FLAG_LO  = 8;   // ev0, ev1, cyc
   localparam int B_CODE1_LO = 12;
   localparam int B_CODE0_LO = 20;
   localparam int CODE_W     = 8;
   localparam int N_CNT      = 3;   // index 0: ev0, 1: ev1, 2: cyc
endpackage

// File: rtl/evmon_evsel.sv
module evmon_evsel #(
   parameter int                EVT_W     = 19,
   parameter logic [EVT_W-1:0]  DEAD_MASK = '0,
   parameter int                EXT_CODE  = 32
) (
   input  logic [7:0]       code,
   input  logic [EVT_W-1:0] lines,
   input  logic             ext_sig,
   output logic             hit
);
   always_comb begin
      hit = (code == 8'(EXT_CODE)) && ext_sig;
      for (int i = 0; i < EVT_W; i++) begin
         if ((code == 8'(i)) && !DEAD_MASK[i] && lines[i]) hit = 1'b1;
      end
   end
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   assign wrap = inc && !clr && !load && (cnt == ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (load) cnt <= load_val;
      else if (inc)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/evmon_prescale.sv
module evmon_prescale #(
   parameter int DIV_LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   input  logic div_on,
   output logic tick
);
   localparam logic [DIV_LOG2-1:0] LAST = {DIV_LOG2{1'b1}};
   logic [DIV_LOG2-1:0] pre_q;

   assign tick = div_on ? (pre_q == LAST) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else if (adv) pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
   import evmon_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N_CNT-1:0]  wrap_v,
   output logic              run_q,
   output logic              div_q,
   output logic [N_CNT-1:0]  ien_q,
   output logic [N_CNT-1:0]  flag_q,
   output logic [7:0]        code0_q,
   output logic [7:0]        code1_q,
   output logic              clr_ev_p,
   output logic              clr_cyc_p,
   output logic [DATA_W-1:0] word
);
   logic [N_CNT-1:0] flag_clr;

   assign clr_ev_p  = wr_ctrl && wdata[B_CLR_EV];
   assign clr_cyc_p = wr_ctrl && wdata[B_CLR_CYC];
   assign flag_clr  = wr_ctrl ? wdata[B_FLAG_LO +: N_CNT] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         div_q   <= 1'b0;
         ien_q   <= '0;
         code0_q <= '0;
         code1_q <= '0;
      end else if (wr_ctrl) begin
         run_q   <= wdata[B_RUN];
         div_q   <= wdata[B_DIV];
         ien_q   <= wdata[B_IEN_LO +: N_CNT];
         code0_q <= wdata[B_CODE0_LO +: CODE_W];
         code1_q <= wdata[B_CODE1_LO +: CODE_W];
      end
   end

   // a wrap on the same edge as a clear wins, so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~flag_clr) | wrap_v;
   end

   always_comb begin
      word                           = '0;
      word[B_RUN]                    = run_q;
      word[B_DIV]                    = div_q;
      word[B_IEN_LO +: N_CNT]        = ien_q;
      word[B_FLAG_LO +: N_CNT]       = flag_q;
      word[B_CODE1_LO +: CODE_W]     = code1_q;
      word[B_CODE0_LO +: CODE_W]     = code0_q;
   end
endmodule

// File: rtl/evmon_top.sv
module evmon_top
   import evmon_pkg::*;
#(
   parameter int               CNT_W     = 32,
   parameter int               EVT_W     = 19,
   parameter logic [EVT_W-1:0] DEAD_MASK = 19'h04100,
   parameter int               EXT_CODE  = 32,
   parameter int               DIV_LOG2  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [EVT_W-1:0]  evt_lines,
   input  logic              trace_ext,
   output logic              irq
);
   // elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("evmon_top: CNT_W must lie in 2..32");
   end
   if (EVT_W < 1 || EVT_W > EXT_CODE) begin : g_bad_evt_w
      $error("evmon_top: EVT_W must lie below the trace code");
   end
   if (EXT_CODE > 255) begin : g_bad_ext
      $error("evmon_top: EXT_CODE must fit the 8-bit code field");
   end
   if (DIV_LOG2 < 0 || DIV_LOG2 > 16) begin : g_bad_div
      $error("evmon_top: DIV_LOG2 must lie in 0..16");
   end

   logic             wr_ctrl;
   logic             run_q, div_q;
   logic [N_CNT-1:0] ien_q, flag_q, wrap_v;
   logic [7:0]       code0_q, code1_q;
   logic             clr_ev_p, clr_cyc_p;
   logic [31:0]      ctrl_word;

   logic [7:0]       ev_code [2];
   logic [1:0]       ev_hit, ev_inc, ev_load, ev_wrap;
   logic [CNT_W-1:0] ev_cnt [2];
   logic [CNT_W-1:0] cyc_cnt;
   logic             cyc_tick, cyc_inc, cyc_wrap;

   assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);

   evmon_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .wdata     (reg_wdata),
      .wrap_v    (wrap_v),
      .run_q     (run_q),
      .div_q     (div_q),
      .ien_q     (ien_q),
      .flag_q    (flag_q),
      .code0_q   (code0_q),
      .code1_q   (code1_q),
      .clr_ev_p  (clr_ev_p),
      .clr_cyc_p (clr_cyc_p),
      .word      (ctrl_word)
   );

   assign ev_code[0] = code0_q;
   assign ev_code[1] = code1_q;

   for (genvar i = 0; i < 2; i++) begin : g_ev
      assign ev_load[i] = reg_wr && (reg_sel == ((i == 0) ? SEL_EV0 : SEL_EV1));
      assign ev_inc[i]  = run_q && ev_hit[i];

      evmon_evsel #(
         .EVT_W     (EVT_W),
         .DEAD_MASK (DEAD_MASK),
         .EXT_CODE  (EXT_CODE)
      ) u_sel (
         .code    (ev_code[i]),
         .lines   (evt_lines),
         .ext_sig (trace_ext),
         .hit     (ev_hit[i])
      );

      evmon_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr_ev_p),
         .load     (ev_load[i]),
         .load_val (reg_wdata[CNT_W-1:0]),
         .inc      (ev_inc[i]),
         .cnt      (ev_cnt[i]),
         .wrap     (ev_wrap[i])
      );
   end

   if (DIV_LOG2 > 0) begin : g_div
      evmon_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr_cyc_p),
         .adv    (run_q && div_q),
         .div_on (div_q),
         .tick   (cyc_tick)
      );
   end else begin : g_nodiv
      assign cyc_tick = 1'b1;
   end

   assign cyc_inc = run_q && cyc_tick;

   evmon_counter #(.CNT_W(CNT_W)) u_cyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_cyc_p),
      .load     (reg_wr && (reg_sel == SEL_CYC)),
      .load_val (reg_wdata[CNT_W-1:0]),
      .inc      (cyc_inc),
      .cnt      (cyc_cnt),
      .wrap     (cyc_wrap)
   );

   assign wrap_v = {cyc_wrap, ev_wrap[1], ev_wrap[0]};
   assign irq    = |(flag_q & ien_q);

   always_comb begin
      unique case (reg_sel)
         SEL_CTRL: reg_rdata = ctrl_word;
         SEL_CYC:  reg_rdata = 32'(cyc_cnt);
         SEL_EV0:  reg_rdata = 32'(ev_cnt[0]);
         default:  reg_rdata = 32'(ev_cnt[1]);
      endcase
   end
endmodule

// File: rtl/evmon_chk.sv
module evmon_chk #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_sel,
   input  logic             reg_wr,
   input  logic [31:0]      reg_wdata,
   input  logic [31:0]      reg_rdata,
   input  logic             irq,
   input  logic             run_q,
   input  logic             div_q,
   input  logic [2:0]       flag_q,
   input  logic [7:0]       code0_q,
   input  logic [1:0]       ev_inc,
   input  logic [CNT_W-1:0] ev_cnt0,
   input  logic [CNT_W-1:0] ev_cnt1,
   input  logic [CNT_W-1:0] cyc_cnt
);
   localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

   assert_irq_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd0) |-> (irq == |(reg_rdata[10:8] & reg_rdata[6:4])));

   assert_clr_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd0) |-> (reg_rdata[2:1] == 2'b00));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !reg_wr) |=> ($stable(cyc_cnt) && $stable(ev_cnt0) && $stable(ev_cnt1)));

   assert_cycle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !div_q && !reg_wr) |=> (cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1)));

   assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_inc[0] && (ev_cnt0 == ONES) && !reg_wr) |=> (flag_q[0] && (ev_cnt0 == '0)));

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[2] && !(reg_wr && reg_sel == 2'd0 && reg_wdata[10])) |=> flag_q[2]);

   assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd0 && reg_wdata[8] && !(ev_inc[0] && ev_cnt0 == ONES)) |=> !flag_q[0]);

   assert_dead_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((code0_q == 8'h08) && !reg_wr) |=> $stable(ev_cnt0));
endmodule

bind evmon_top evmon_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .run_q     (run_q),
   .div_q     (div_q),
   .flag_q    (flag_q),
   .code0_q   (code0_q),
   .ev_inc    (ev_inc),
   .ev_cnt0   (ev_cnt[0]),
   .ev_cnt1   (ev_cnt[1]),
   .cyc_cnt   (cyc_cnt)
);

// File: tb/evmon_top_tb_top.sv
module evmon_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [18:0] evt_lines = '0;
   logic        trace_ext = 1'b0;
   logic        irq;

   always #10 clk = ~clk;   // 50 MHz

   evmon_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_lines(evt_lines),
      .trace_ext(trace_ext), .irq(irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   event  probe_ev;

   localparam logic [18:0] ALL = 19'h7FFFF;

   // monitor: pops the expected item and compares it with the ports
   initial begin
      forever begin
         item_t it;
         logic [31:0] act;
         @(probe_ev);
         it  = q.pop_front();
         act = it.is_irq ? {31'b0, irq} : reg_rdata;
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   function automatic logic [31:0] ctl(bit run, bit cev, bit ccyc, bit dv,
                                       logic [2:0] ien, logic [2:0] fclr,
                                       logic [7:0] c0, logic [7:0] c1);
      return {4'b0, c0, c1, 1'b0, fclr, 1'b0, ien, dv, ccyc, cev, run};
   endfunction

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      evt_lines = '0; trace_ext = 1'b0;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic step(logic [18:0] ev, logic ext);
      @(negedge clk);
      evt_lines = ev; trace_ext = ext;
      @(posedge clk); #1;
      evt_lines = '0; trace_ext = 1'b0;
   endtask

   task automatic expect_rd(logic [1:0] sel, logic [31:0] e, string tag);
      item_t it;
      @(negedge clk);
      reg_sel = sel; reg_wr = 1'b0;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      q.push_back(it);
      #5 ->probe_ev;
   endtask

   task automatic expect_irq(logic e, string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
      q.push_back(it);
      #5 ->probe_ev;
   endtask

   initial begin
      logic [31:0] w;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      expect_rd(2'd0, 32'h0, "R1 ctrl");
      expect_rd(2'd1, 32'h0, "R1 cyc");
      expect_rd(2'd2, 32'h0, "R1 ev0");
      expect_rd(2'd3, 32'h0, "R1 ev1");
      expect_irq(1'b0, "R1 irq");

      // R2 register map and loads
      wr(2'd1, 32'hDEADBEEF);
      wr(2'd2, 32'h12345678);
      wr(2'd3, 32'hFFFFFFFF);
      expect_rd(2'd1, 32'hDEADBEEF, "R2 cyc load");
      expect_rd(2'd2, 32'h12345678, "R2 ev0 load");
      expect_rd(2'd3, 32'hFFFFFFFF, "R2 ev1 load");
      wr(2'd3, 32'h0);
      expect_rd(2'd3, 32'h0, "R2 ev1 zero");

      // R3 run bit low: nothing counts
      wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h07, 8'h05));
      repeat (3) step(ALL, 1'b1);
      expect_rd(2'd2, 32'h12345678, "R3 ev0 idle");
      expect_rd(2'd1, 32'hDEADBEEF, "R3 cyc idle");

      // R4 / R3 / R9 mixed patterns, clears on the enabling write
      wr(2'd0, ctl(1, 1, 1, 0, 3'b000, 3'b000, 8'h07, 8'h05));
      step(19'h000A0, 1'b0);
      step(19'h00080, 1'b0);
      step(19'h000A0, 1'b0);
      step(19'h00000, 1'b0);
      step(19'h00008, 1'b0);
      wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h07, 8'h05));
      expect_rd(2'd2, 32'd3, "R4 ev0 code7");
      expect_rd(2'd3, 32'd2, "R4 ev1 code5");
      expect_rd(2'd1, 32'd6, "R3 cyc every cycle");
      expect_rd(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h07, 8'h05), "R4 ctrl fields");

      // R5 trace code and dead code
      wr(2'd0, ctl(1, 1, 1, 0, 3'b000, 3'b000, 8'h20, 8'h08));
      repeat (2) step(ALL, 1'b0);
      repeat (3) step(ALL, 1'b1);
      wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'h08));
      expect_rd(2'd2, 32'd3, "R5 trace code");
      expect_rd(2'd3, 32'd0, "R5 code 0x08 dead");
      wr(2'd0, ctl(1, 1, 1, 0, 3'b000, 3'b000, 8'h0E, 8'h12));
      repeat (3) step(ALL, 1'b1);
      wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h0E, 8'h12));
      expect_rd(2'd2, 32'd0, "R5 code 0x0E dead");
      expect_rd(2'd3, 32'd3, "R4 code 0x12 live");
      wr(2'd0, ctl(1, 1, 0, 0, 3'b000, 3'b000, 8'hFF, 8'h13));
      repeat (2) step(ALL, 1'b1);
      wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'h13));
      expect_rd(2'd2, 32'd0, "R5 code 0xFF dead");
      expect_rd(2'd3, 32'd0, "R5 code 0x13 dead");
      // cycle counter: 4 from the prior run, plus 3 here
      expect_rd(2'd1, 32'd7, "R3 cyc accumulates");

      // R6 / R8 event counter 0 wraps with its interrupt enabled
      wr(2'd3, 32'd3);
      wr(2'd2, 32'hFFFFFFFE);
      wr(2'd0, ctl(1, 0, 0, 0, 3'b001, 3'b000, 8'h07, 8'h08));
      repeat (2) step(19'h00080, 1'b0);
      wr(2'd0, ctl(0, 0, 0, 0, 3'b001, 3'b000, 8'h07, 8'h08));
      w = ctl(0, 0, 0, 0, 3'b001, 3'b000, 8'h07, 8'h08) | 32'h100;
      expect_rd(2'd2, 32'h0, "R6 ev0 wraps to zero");
      expect_rd(2'd0, w, "R6 ev0 flag set");
      expect_irq(1'b1, "R8 irq ev0");

      // R7 write back the word just read
      wr(2'd0, w);
      expect_rd(2'd0, w & ~32'h100, "R7 flag cleared, rest kept");
      expect_irq(1'b0, "R7 irq low after write-back");
      expect_rd(2'd3, 32'd3, "R7 ev1 untouched");
      expect_rd(2'd1, 32'd10, "R7 cyc untouched");

      // R6 / R8 cycle counter wraps with its interrupt disabled
      wr(2'd1, 32'hFFFFFFFF);
      wr(2'd0, ctl(1, 0, 0, 0, 3'b000, 3'b000, 8'h08, 8'h08));
      wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h08, 8'h08));
      expect_rd(2'd1, 32'h0, "R6 cyc wraps");
      expect_rd(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h08, 8'h08) | 32'h400,
                "R6 cyc flag without enable");
      expect_irq(1'b0, "R8 irq masked");
      wr(2'd0, ctl(0, 0, 0, 0, 3'b100, 3'b000, 8'h08, 8'h08));
      expect_irq(1'b1, "R8 irq after enable");
      wr(2'd0, ctl(0, 0, 0, 0, 3'b100, 3'b100, 8'h08, 8'h08));
      expect_irq(1'b0, "R7 irq after clear");
      expect_rd(2'd0, ctl(0, 0, 0, 0, 3'b100, 3'b000, 8'h08, 8'h08), "R7 ctrl after clear");

      // R9 one-shot clear bits
      wr(2'd2, 32'h55); wr(2'd3, 32'h66); wr(2'd1, 32'h77);
      wr(2'd0, ctl(0, 1, 0, 0, 3'b000, 3'b000, 8'h08, 8'h08));
      expect_rd(2'd2, 32'h0, "R9 ev0 cleared");
      expect_rd(2'd3, 32'h0, "R9 ev1 cleared");
      expect_rd(2'd1, 32'h77, "R9 cyc kept");
      expect_rd(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h08, 8'h08), "R9 clear bits read 0");
      wr(2'd2, 32'h99);
      wr(2'd0, ctl(0, 0, 1, 0, 3'b000, 3'b000, 8'h08, 8'h08));
      expect_rd(2'd1, 32'h0, "R9 cyc cleared");
      expect_rd(2'd2, 32'h99, "R9 ev0 kept");

      // R10 divider: 128 run cycles give 2 counts
      wr(2'd0, ctl(1, 0, 1, 1, 3'b000, 3'b000, 8'h08, 8'h08));
      for (int i = 0; i < 127; i++) step('0, 1'b0);
      wr(2'd0, ctl(0, 0, 0, 1, 3'b000, 3'b000, 8'h08, 8'h08));
      expect_rd(2'd1, 32'd2, "R10 divide by 64");
      expect_rd(2'd0, ctl(0, 0, 0, 1, 3'b000, 3'b000, 8'h08, 8'h08), "R10 div bit readback");
      // 30 more cycles leave the prescaler at 30
      wr(2'd0, ctl(1, 0, 0, 1, 3'b000, 3'b000, 8'h08, 8'h08));
      for (int i = 0; i < 29; i++) step('0, 1'b0);
      wr(2'd0, ctl(0, 0, 0, 1, 3'b000, 3'b000, 8'h08, 8'h08));
      expect_rd(2'd1, 32'd2, "R10 partial period");
      // clear bit resets the prescaler: 63 cycles give no count
      wr(2'd0, ctl(1, 0, 1, 1, 3'b000, 3'b000, 8'h08, 8'h08));
      for (int i = 0; i < 62; i++) step('0, 1'b0);
      wr(2'd0, ctl(0, 0, 0, 1, 3'b000, 3'b000, 8'h08, 8'h08));
      expect_rd(2'd1, 32'd0, "R10 prescaler cleared");
      // the 64th cycle counts
      wr(2'd0, ctl(1, 0, 0, 1, 3'b000, 3'b000, 8'h08, 8'h08));
      wr(2'd0, ctl(0, 0, 0, 1, 3'b000, 3'b000, 8'h08, 8'h08));
      expect_rd(2'd1, 32'd1, "R10 64th cycle");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule